// File: doc/BRIEF.md
# Two-Format 16-bit Processor Core

This block is a single-cycle 16-bit processor core built around two architectural registers: an address/constant register (A) and a data register (D). It also holds a program counter. On every enabled clock edge it completes one instruction. The core presents the program counter to an external instruction memory and takes the returned instruction word back in the same cycle. It reads and writes an external data memory at the address held in A. The instruction and data memories, and any board-level I/O, sit outside the block.

There are two instruction formats. A word with bit 15 clear is a load-immediate: its low 15 bits go into A. This is the only way to form a data address or a branch target. A word with bit 15 set is a compute instruction. It chooses an ALU function, picks the second operand from A or from memory at A, stores the result to any mix of A, D and memory, and can branch to the address held in A according to the sign and zero state of the result.

A clock-enable input gates every state change and every memory write. This lets the system around the core run it at full rate or advance it one instruction per pulse.

Top module: `cpu16_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, A and D to zero. The data-memory write enable is low while no compute instruction asks for a store.
- R2: An instruction with bit 15 = 0 loads A with bits 14:0 zero-extended to 16 bits. On the next cycle the data-memory address output shows the low 14 bits of A, and the program counter has advanced by one.
- R3: While `step_en` is low, no register changes and the write enable stays low. This holds whatever instruction is presented.
- R4: In a compute instruction (bit 15 = 1), the first ALU operand x is D. The ALU applies six control bits, each acting only when it is set, in this order:
  - bit 11 forces x to zero;
  - bit 10 inverts x;
  - bit 9 forces y to zero;
  - bit 8 inverts y;
  - bit 7 selects x+y (when 1) or x AND y (when 0);
  - bit 6 inverts the result.
- R5: Compute bit 12 selects the second ALU operand y. When it is 0, y is A. When it is 1, y is the data-memory read data.
- R6: Compute bits 5, 4 and 3 independently enable storing the ALU result to A, D and memory. Several may be set at once. The memory store uses the address that A held before the instruction.
- R7: Compute bits 2, 1 and 0 request a branch when the result is negative (bit 15 set), zero, or positive, respectively. When any requested condition holds, the program counter loads A; otherwise it increments.
- R8: A branch target is the value A held before the instruction, even when the same instruction also writes A. The program counter is 15 bits wide and wraps from 0x7FFF to 0.
- R9: `dmem_we_o` is high only for a compute instruction with bit 3 set while `step_en` is high. `dmem_wdata_o` then carries the ALU result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Clock enable; one instruction completes per enabled edge |
| instr_i | input | 16 | Instruction word fetched at `pc_o` |
| pc_o | output | 15 | Program counter, the instruction address |
| dmem_addr_o | output | 14 | Data-memory address (low bits of A) |
| dmem_wdata_o | output | 16 | Data-memory write data (ALU result) |
| dmem_we_o | output | 1 | Data-memory write enable for the current edge |
| dmem_rdata_i | input | 16 | Data-memory read data at `dmem_addr_o` |

## Verification
The bench targets three hazards:
- An instruction that writes A and also stores to memory or branches. A design that used the new A would store to the wrong word or jump to the wrong place.
- Each of the eight branch masks against negative, zero and positive results. Mixing up the condition bits or the sign test shows up as a wrong program counter.
- A stalled cycle that carries a full store-and-branch instruction, together with a program counter at 0x7FFF and a zero-extended 15-bit immediate. A leaky enable, a missed wrap or sign extension would each corrupt a later observed value.

It also sweeps the common ALU functions with both operand sources, so an inverted control bit or a swapped operand select changes the stored data.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

   localparam int unsigned INSTR_W   = 16;
   localparam int unsigned IMM_W     = 15;
   localparam int unsigned KIND_BIT  = 15;
   localparam int unsigned YSEL_BIT  = 12;
   localparam int unsigned ALU_HI    = 11;
   localparam int unsigned ALU_LO    = 6;
   localparam int unsigned DST_HI    = 5;
   localparam int unsigned DST_LO    = 3;
   localparam int unsigned BR_HI     = 2;
   localparam int unsigned BR_LO     = 0;

   typedef struct packed {
      logic zx;
      logic nx;
      logic zy;
      logic ny;
      logic f_add;
      logic no;
   } alu_ctl_t;

   typedef struct packed {
      logic to_a;
      logic to_d;
      logic to_m;
   } dest_t;

   typedef struct packed {
      logic on_neg;
      logic on_zero;
      logic on_pos;
   } br_t;

   typedef struct packed {
      logic             is_comp;
      logic             y_mem;
      alu_ctl_t         alu;
      dest_t            dst;
      br_t              br;
      logic [IMM_W-1:0] imm;
   } dec_t;

endpackage

// File: rtl/cpu16_decode.sv
module cpu16_decode
   import cpu16_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output dec_t               dec
);

   always_comb begin
      dec.is_comp = instr[KIND_BIT];
      dec.y_mem   = instr[KIND_BIT] & instr[YSEL_BIT];
      dec.alu     = alu_ctl_t'(instr[ALU_HI:ALU_LO]);
      dec.dst     = instr[KIND_BIT] ? dest_t'(instr[DST_HI:DST_LO]) : '0;
      dec.br      = instr[KIND_BIT] ? br_t'(instr[BR_HI:BR_LO]) : '0;
      dec.imm     = instr[IMM_W-1:0];
   end

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
   import cpu16_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   input  alu_ctl_t          ctl,
   output logic [DATA_W-1:0] res,
   output logic              zero,
   output logic              neg
);

   logic [DATA_W-1:0] xc;
   logic [DATA_W-1:0] yc;
   logic [DATA_W-1:0] and_v;
   logic [DATA_W-1:0] sum_v;
   logic [DATA_W-1:0] pre;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign xc[i]    = (x[i] & ~ctl.zx) ^ ctl.nx;
      assign yc[i]    = (y[i] & ~ctl.zy) ^ ctl.ny;
      assign and_v[i] = xc[i] & yc[i];
   end

   assign sum_v = xc + yc;
   assign pre   = ctl.f_add ? sum_v : and_v;
   assign res   = ctl.no ? ~pre : pre;
   assign zero  = (res == '0);
   assign neg   = res[DATA_W-1];

endmodule

// File: rtl/cpu16_pc.sv
module cpu16_pc #(
   parameter int unsigned PC_W = 15
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en,
   input  logic            load,
   input  logic [PC_W-1:0] target,
   output logic [PC_W-1:0] pc_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= '0;
      end else if (en) begin
         pc_q <= load ? target : pc_q + 1'b1;
      end
   end

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
   import cpu16_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned PC_W    = 15,
   parameter int unsigned DADDR_W = 14
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               step_en,
   input  logic [DATA_W-1:0]  instr_i,
   output logic [PC_W-1:0]    pc_o,
   output logic [DADDR_W-1:0] dmem_addr_o,
   output logic [DATA_W-1:0]  dmem_wdata_o,
   output logic               dmem_we_o,
   input  logic [DATA_W-1:0]  dmem_rdata_i
);

   initial begin
      assert (DATA_W == INSTR_W) else $fatal(1, "DATA_W must equal the 16-bit instruction width");
      assert (PC_W >= 1 && PC_W <= IMM_W) else $fatal(1, "PC_W must fit in the immediate field");
      assert (DADDR_W >= 1 && DADDR_W <= IMM_W) else $fatal(1, "DADDR_W must fit in the immediate field");
   end

   dec_t              dec;
   logic [DATA_W-1:0] a_q;
   logic [DATA_W-1:0] d_q;
   logic [DATA_W-1:0] y_op;
   logic [DATA_W-1:0] alu_res;
   logic              alu_zero;
   logic              alu_neg;
   logic              take_br;
   logic [DATA_W-1:0] a_nxt;

   cpu16_decode u_dec (
      .instr (instr_i),
      .dec   (dec)
   );

   assign y_op = dec.y_mem ? dmem_rdata_i : a_q;

   cpu16_alu #(.DATA_W(DATA_W)) u_alu (
      .x    (d_q),
      .y    (y_op),
      .ctl  (dec.alu),
      .res  (alu_res),
      .zero (alu_zero),
      .neg  (alu_neg)
   );

   assign take_br = dec.is_comp &
                    ((dec.br.on_neg  & alu_neg) |
                     (dec.br.on_zero & alu_zero) |
                     (dec.br.on_pos  & ~alu_neg & ~alu_zero));

   always_comb begin
      if (!dec.is_comp)     a_nxt = DATA_W'(dec.imm);
      else if (dec.dst.to_a) a_nxt = alu_res;
      else                   a_nxt = a_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         d_q <= '0;
      end else if (step_en) begin
         a_q <= a_nxt;
         if (dec.is_comp && dec.dst.to_d) d_q <= alu_res;
      end
   end

   cpu16_pc #(.PC_W(PC_W)) u_pc (
      .clk    (clk),
      .rst    (rst),
      .en     (step_en),
      .load   (take_br),
      .target (a_q[PC_W-1:0]),
      .pc_q   (pc_o)
   );

   assign dmem_addr_o  = a_q[DADDR_W-1:0];
   assign dmem_wdata_o = alu_res;
   assign dmem_we_o    = step_en & dec.is_comp & dec.dst.to_m;

endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned PC_W    = 15,
   parameter int unsigned DADDR_W = 14
) (
   input logic               clk,
   input logic               rst,
   input logic               step_en,
   input logic [DATA_W-1:0]  instr_i,
   input logic [PC_W-1:0]    pc_o,
   input logic [DADDR_W-1:0] dmem_addr_o,
   input logic               dmem_we_o,
   input logic [DATA_W-1:0]  a_q
);

   // R1
   reset_pc_zero_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (pc_o == '0 && dmem_addr_o == '0));

   // R2
   imm_load_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && !instr_i[15]) |=> (dmem_addr_o == $past(instr_i[DADDR_W-1:0])));

   // R3
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> ($stable(pc_o) && $stable(dmem_addr_o)));

   // R9
   store_gate_chk: assert property (@(posedge clk) disable iff (rst)
      dmem_we_o |-> (step_en && instr_i[15] && instr_i[3]));

   // R8
   branch_old_a_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && instr_i[15] && instr_i[2:0] == 3'b111) |=> (pc_o == $past(a_q[PC_W-1:0])));

   // R7
   no_branch_inc_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && instr_i[15] && instr_i[2:0] == 3'b000) |=> (pc_o == PC_W'($past(pc_o) + 1'b1)));

endmodule

bind cpu16_core cpu16_core_chk #(
   .DATA_W  (DATA_W),
   .PC_W    (PC_W),
   .DADDR_W (DADDR_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .step_en     (step_en),
   .instr_i     (instr_i),
   .pc_o        (pc_o),
   .dmem_addr_o (dmem_addr_o),
   .dmem_we_o   (dmem_we_o),
   .a_q         (a_q)
);

// File: tb/cpu16_core_tb.sv
module cpu16_core_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        step_en = 1'b0;
   logic [15:0] instr = 16'h0000;
   logic [15:0] rdata = 16'h0000;
   logic [14:0] pc_o;
   logic [13:0] dmem_addr_o;
   logic [15:0] dmem_wdata_o;
   logic        dmem_we_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] ea = '0;
   logic [15:0] ed = '0;
   logic [14:0] epc = '0;

   typedef struct {
      logic [14:0] pc;
      logic [13:0] addr;
      string       tag;
   } post_t;

   post_t q[$];

   always #4 clk = ~clk;

   cpu16_core u_dut (
      .clk          (clk),
      .rst          (rst),
      .step_en      (step_en),
      .instr_i      (instr),
      .pc_o         (pc_o),
      .dmem_addr_o  (dmem_addr_o),
      .dmem_wdata_o (dmem_wdata_o),
      .dmem_we_o    (dmem_we_o),
      .dmem_rdata_i (rdata)
   );

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_alu(input logic [5:0] c, input logic [15:0] x, input logic [15:0] y);
      logic [15:0] a = x;
      logic [15:0] b = y;
      logic [15:0] r;
      if (c[5]) a = '0;
      if (c[4]) a = ~a;
      if (c[3]) b = '0;
      if (c[2]) b = ~b;
      r = c[1] ? a + b : a & b;
      if (c[0]) r = ~r;
      return r;
   endfunction

   function automatic logic [15:0] ci(input bit ym, input logic [5:0] c, input logic [2:0] d, input logic [2:0] j);
      return {3'b111, ym, c, d, j};
   endfunction

   // driver: drive one instruction, check same-cycle outputs, queue the post-edge expectation
   task automatic run(input logic [15:0] ins, input logic [15:0] rd, input logic en, input string tag);
      logic        is_c;
      logic [15:0] y;
      logic [15:0] res;
      logic        ng, zr, take, we_exp;
      post_t       it;
      @(negedge clk);
      instr = ins; rdata = rd; step_en = en;
      #1;
      is_c   = ins[15];
      y      = ins[12] ? rd : ea;
      res    = ref_alu(ins[11:6], ed, y);
      ng     = res[15];
      zr     = (res == 16'h0);
      take   = is_c && ((ins[2] && ng) || (ins[1] && zr) || (ins[0] && !ng && !zr));
      we_exp = is_c && ins[3] && en;
      chk(dmem_we_o == we_exp, tag, "we", int'(dmem_we_o), int'(we_exp));
      if (we_exp) chk(dmem_wdata_o == res, tag, "wdata", int'(dmem_wdata_o), int'(res));
      if (en) begin
         epc = take ? ea[14:0] : epc + 15'd1;
         if (is_c && ins[4]) ed = res;
         if (!is_c) ea = {1'b0, ins[14:0]};
         else if (ins[5]) ea = res;
      end
      it.pc = epc; it.addr = ea[13:0]; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic ains(input logic [14:0] v, input string tag);
      run({1'b0, v}, 16'h0, 1'b1, tag);
   endtask

   // monitor: after each edge, compare the state-dependent outputs
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            post_t it;
            it = q.pop_front();
            chk(pc_o == it.pc, it.tag, "pc", int'(pc_o), int'(it.pc));
            chk(dmem_addr_o == it.addr, it.tag, "addr", int'(dmem_addr_o), int'(it.addr));
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog all actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   logic [5:0] ops [18] = '{6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000,
                            6'b001101, 6'b110001, 6'b001111, 6'b110011, 6'b011111,
                            6'b110111, 6'b001110, 6'b110010, 6'b000010, 6'b010011,
                            6'b000111, 6'b000000, 6'b010101};

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      #1;
      // R1 reset state
      chk(pc_o == 15'd0, "R1", "pc after reset", int'(pc_o), 0);
      chk(dmem_addr_o == 14'd0, "R1", "addr after reset", int'(dmem_addr_o), 0);
      chk(dmem_we_o == 1'b0, "R1", "we after reset", int'(dmem_we_o), 0);
      run(ci(0, 6'b001100, 3'b001, 3'b000), 16'h0, 1'b1, "R1_d_zero");

      // R2 immediate load, zero extension visible through A -> memory
      ains(15'h1234, "R2");
      run(ci(0, 6'b110000, 3'b010, 3'b000), 16'h0, 1'b1, "R4_d_from_a");
      ains(15'h7FFF, "R2_top");
      run(ci(0, 6'b110000, 3'b001, 3'b000), 16'h0, 1'b1, "R2_zext");
      ains(15'h0F0F, "R2");

      // R4 ALU sweep with y = A, R5 with y = memory
      foreach (ops[k]) run(ci(0, ops[k], 3'b001, 3'b000), 16'h0, 1'b1, "R4_op");
      foreach (ops[k]) run(ci(1, ops[k], 3'b001, 3'b000), 16'h00AA, 1'b1, "R5_op");
      run(ci(1, 6'b000010, 3'b001, 3'b000), 16'h8001, 1'b1, "R5_dplusm");

      // R6 all destinations at once; store uses old A
      run(ci(1, 6'b110111, 3'b111, 3'b000), 16'h3FFF, 1'b1, "R6_amd");
      run(ci(0, 6'b001100, 3'b001, 3'b000), 16'h0, 1'b1, "R6_d_check");
      run(ci(0, 6'b110000, 3'b001, 3'b000), 16'h0, 1'b1, "R6_a_check");

      // R3 stall with a store-and-branch instruction
      run(ci(1, 6'b111111, 3'b111, 3'b111), 16'h5555, 1'b0, "R3_stall");
      run(ci(1, 6'b000000, 3'b111, 3'b111), 16'h0, 1'b0, "R3_stall");
      run(ci(0, 6'b001100, 3'b001, 3'b000), 16'h0, 1'b1, "R3_d_kept");

      // R7 every branch mask against negative, zero, positive results
      for (int s = 0; s < 3; s++) begin
         for (int j = 0; j < 8; j++) begin
            ains(15'h0100 + 15'(16 * s + j), "R7_tgt");
            run(ci(0, (s == 0) ? 6'b111010 : (s == 1) ? 6'b101010 : 6'b111111,
                   3'b000, 3'(j)), 16'h0, 1'b1, "R7_br");
         end
      end
      ains(15'h0005, "R7");
      run(ci(0, 6'b110000, 3'b010, 3'b000), 16'h0, 1'b1, "R7_d5");
      ains(15'h0222, "R7");
      run(ci(0, 6'b001100, 3'b000, 3'b001), 16'h0, 1'b1, "R7_dgt");
      ains(15'h0333, "R7");
      run(ci(0, 6'b001100, 3'b000, 3'b100), 16'h0, 1'b1, "R7_dlt");

      // R8 branch target is old A even when A is written
      ains(15'h0300, "R8");
      run(ci(0, 6'b110111, 3'b100, 3'b111), 16'h0, 1'b1, "R8_old_a");
      run(ci(0, 6'b110000, 3'b001, 3'b000), 16'h0, 1'b1, "R8_new_a");
      // R8 wrap
      ains(15'h7FFF, "R8");
      run(ci(0, 6'b101010, 3'b000, 3'b111), 16'h0, 1'b1, "R8_to_top");
      ains(15'h0001, "R8_wrap");

      // R9 no store without bit 3
      run(ci(0, 6'b111111, 3'b110, 3'b000), 16'h0, 1'b1, "R9_nostore");
      run({1'b0, 15'h7FFF}, 16'h0, 1'b1, "R9_imm_bit3");

      // R1 reset in mid-run
      @(negedge clk);
      rst = 1'b1; step_en = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      ea = '0; ed = '0; epc = '0;
      #1;
      chk(pc_o == 15'd0, "R1", "pc after mid reset", int'(pc_o), 0);
      chk(dmem_addr_o == 14'd0, "R1", "addr after mid reset", int'(dmem_addr_o), 0);
      run(ci(0, 6'b001100, 3'b001, 3'b000), 16'h0, 1'b1, "R1_d_cleared");

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule